// File: doc/BRIEF.md
# Read Data Checker with Failure Capture

This block sits on the response side of a memory traffic generator. On every valid read response it compares the returned word against an expected word that the command side has already aligned with that response. It keeps a running record of the result. A per-bit pass-not-fail vector tracks which bit positions have ever mismatched. A 64-bit counter counts failing reads and another counts compared reads. A snapshot holds the address, expected word and received word of the first mismatch.

In write-once-read-many mode the first mismatch stops traffic. The checker then asks for one targeted re-read of the failing address and keeps the data that comes back, so software can tell a stored corruption from a transient one. A four-bit clear input resets each status group on its own. When the test-complete input is high, the pass and fail flags report the overall verdict.

The re-read sequencer is a four-state machine:
- `ST_RUN` (normal comparison). A mismatch while write-once mode is on moves it to `ST_ISSUE`.
- `ST_ISSUE` (re-read request, one cycle). It always moves on to `ST_WAIT`.
- `ST_WAIT` (waiting for the re-read data). The first valid response moves it to `ST_HOLD`.
- `ST_HOLD` (stopped). Clear bit 3 returns it to `ST_RUN`.

Top module: `rdchk`

## Requirements
- R1: After reset the pass-not-fail vector is all ones. Both counters are zero. First-failure valid and re-read valid are 0 and their fields are zero. Traffic stop and re-read request are 0, and pass and fail read 0.
- R2: A response is compared only in `ST_RUN`. Each bit where the received data differs from the expected data drives that pass-not-fail bit to 0. The bit stays 0 until clear bit 0.
- R3: The failed-read count is 64 bits wide and rises by one for each compared response that mismatches. It is output as a low and a high 32-bit half, and clear bit 0 zeroes it.
- R4: The total-read count is 64 bits wide and rises by one for each compared response. It is output as low and high halves, and clear bit 1 zeroes it.
- R5: The first mismatch while no failure is held captures the address, expected data and received data, and sets first-failure valid. Later mismatches leave the snapshot unchanged. Clear bit 2 zeroes the snapshot and its valid flag.
- R6: When a clear bit and a new event for the same group arrive in one cycle, the event is kept. The pass-not-fail vector restarts from all ones and then takes the new mismatch. The failed count restarts at 1. A new first-failure snapshot is taken, and re-read data arriving in `ST_WAIT` is stored.
- R7: In `ST_RUN` with write-once mode on, a mismatch raises traffic stop and the re-read request from the next cycle. The re-read request lasts exactly one cycle, and the re-read address equals the failing response's address.
- R8: While traffic is stopped, no response is compared or counted. Responses during `ST_ISSUE` are ignored. The first valid response in `ST_WAIT` is stored as re-read data with re-read valid set, and later responses in `ST_HOLD` are ignored.
- R9: Clear bit 3 zeroes the re-read data and its valid flag. In `ST_HOLD` it also returns the sequencer to `ST_RUN` and drops traffic stop.
- R10: Pass reads 1 only when test complete is high and the pass-not-fail vector is all ones. Fail reads 1 only when test complete is high and some pass-not-fail bit is 0. Both read 0 while test complete is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | A read response is present this cycle |
| rsp_addr | input | AW | Address of the response |
| rsp_data | input | DW | Received read data |
| exp_data | input | DW | Expected data aligned with the response |
| worm_en | input | 1 | Write-once-read-many mode enable |
| test_done | input | 1 | Run complete; enables pass and fail |
| clr | input | 4 | Clears: bit0 pass-not-fail and failed count, bit1 total count, bit2 first failure, bit3 re-read data and halt |
| pnf_o | output | DW | Sticky per-bit pass-not-fail vector |
| fail_cnt_lo | output | CW/2 | Failed-read count, low half |
| fail_cnt_hi | output | CW/2 | Failed-read count, high half |
| read_cnt_lo | output | CW/2 | Total compared reads, low half |
| read_cnt_hi | output | CW/2 | Total compared reads, high half |
| first_fail_valid | output | 1 | A first-failure snapshot is held |
| first_fail_addr | output | AW | Address of the first failure |
| first_fail_exp | output | DW | Expected data of the first failure |
| first_fail_got | output | DW | Received data of the first failure |
| traffic_stop | output | 1 | Traffic must halt (sequencer not in `ST_RUN`) |
| reread_req | output | 1 | One-cycle request for the targeted re-read |
| reread_addr | output | AW | Address to re-read |
| reread_valid | output | 1 | Re-read data is held |
| reread_data | output | DW | Data returned by the targeted re-read |
| pass_o | output | 1 | Run passed (valid with test_done) |
| fail_o | output | 1 | Run failed (valid with test_done) |

## Verification
The bench aims at clears that land in the same cycle as a mismatch. A design that let the clear win would lose that failure, and the pass-not-fail vector and failed count would show a clean run. It drives a second mismatch after the first is captured; a design that overwrote the snapshot would report the wrong first address. In write-once mode it sends responses during the request cycle, the wait state and the hold state. A sequencer that compared those responses would move the counters, and one that stored the wrong response would keep bad re-read data. A pass or fail flag that did not wait for test complete would show up in the long random run.

// File: rtl/rdchk_pkg.sv
`timescale 1ns/1ps
package rdchk_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_HOLD  = 2'd3
    } rr_state_e;

    localparam int CLR_W   = 4;
    localparam int CLR_PNF = 0;
    localparam int CLR_TOT = 1;
    localparam int CLR_FF  = 2;
    localparam int CLR_RR  = 3;
endpackage

// File: rtl/rdchk_fsm.sv
`timescale 1ns/1ps
module rdchk_fsm
    import rdchk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rsp_valid,
    input  logic          mismatch,
    input  logic [AW-1:0] rsp_addr,
    input  logic          worm_en,
    input  logic          clr_rr,
    output rr_state_e     state_o,
    output logic [AW-1:0] halt_addr,
    output logic          reread_req,
    output logic          traffic_stop,
    output logic          take_reread
);
    rr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (mismatch && worm_en) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_HOLD;
            ST_HOLD:  if (clr_rr) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            halt_addr <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && mismatch && worm_en) halt_addr <= rsp_addr;
        end
    end

    always_comb begin
        state_o      = state_q;
        reread_req   = (state_q == ST_ISSUE);
        traffic_stop = (state_q != ST_RUN);
        take_reread  = (state_q == ST_WAIT) && rsp_valid;
    end

    a_r7_stop_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mismatch && worm_en) |=> (traffic_stop && reread_req));
    a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reread_req |=> !reread_req);
    a_r9_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (traffic_stop && !clr_rr) |=> traffic_stop);
endmodule

// File: rtl/rdchk_stat.sv
`timescale 1ns/1ps
module rdchk_stat #(
    parameter int DW = 32,
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_en,
    input  logic [DW-1:0] diff,
    input  logic          clr_pnf,
    input  logic          clr_tot,
    output logic [DW-1:0] pnf_q,
    output logic [CW-1:0] fail_q,
    output logic [CW-1:0] tot_q
);
    logic bad;
    assign bad = cmp_en && (|diff);

    for (genvar b = 0; b < DW; b++) begin : g_pnf
        always_ff @(posedge clk) begin
            if (!rst_n) pnf_q[b] <= 1'b1;
            else        pnf_q[b] <= (clr_pnf | pnf_q[b]) & ~diff[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= '0;
            tot_q  <= '0;
        end else begin
            fail_q <= (clr_pnf ? '0 : fail_q) + CW'(bad);
            tot_q  <= (clr_tot ? '0 : tot_q) + CW'(cmp_en);
        end
    end

    a_r2_pnf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_pnf |=> ((pnf_q & ~$past(pnf_q)) == '0));
    a_r4_tot_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_tot |=> (tot_q == $past(tot_q) || tot_q == $past(tot_q) + 1'b1));
    a_r3_fail_le_tot: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_pnf && !bad) |=> $stable(fail_q));
endmodule

// File: rtl/rdchk_capture.sv
`timescale 1ns/1ps
module rdchk_capture #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mismatch,
    input  logic [AW-1:0] rsp_addr,
    input  logic [DW-1:0] rsp_data,
    input  logic [DW-1:0] exp_data,
    input  logic          take_reread,
    input  logic          clr_ff,
    input  logic          clr_rr,
    output logic          ff_valid,
    output logic [AW-1:0] ff_addr,
    output logic [DW-1:0] ff_exp,
    output logic [DW-1:0] ff_got,
    output logic          rr_valid,
    output logic [DW-1:0] rr_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_valid <= 1'b0;
            ff_addr  <= '0;
            ff_exp   <= '0;
            ff_got   <= '0;
        end else if (mismatch && (!ff_valid || clr_ff)) begin
            ff_valid <= 1'b1;
            ff_addr  <= rsp_addr;
            ff_exp   <= exp_data;
            ff_got   <= rsp_data;
        end else if (clr_ff) begin
            ff_valid <= 1'b0;
            ff_addr  <= '0;
            ff_exp   <= '0;
            ff_got   <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_valid <= 1'b0;
            rr_data  <= '0;
        end else if (take_reread) begin
            rr_valid <= 1'b1;
            rr_data  <= rsp_data;
        end else if (clr_rr) begin
            rr_valid <= 1'b0;
            rr_data  <= '0;
        end
    end

    a_r5_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_valid && !clr_ff) |=> (ff_valid && $stable(ff_addr) && $stable(ff_got)));
    a_r8_reread_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_valid && !clr_rr && !take_reread) |=> $stable(rr_data));
endmodule

// File: rtl/rdchk.sv
`timescale 1ns/1ps
module rdchk
    import rdchk_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int CW = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsp_valid,
    input  logic [AW-1:0]      rsp_addr,
    input  logic [DW-1:0]      rsp_data,
    input  logic [DW-1:0]      exp_data,
    input  logic               worm_en,
    input  logic               test_done,
    input  logic [CLR_W-1:0]   clr,
    output logic [DW-1:0]      pnf_o,
    output logic [CW/2-1:0]    fail_cnt_lo,
    output logic [CW/2-1:0]    fail_cnt_hi,
    output logic [CW/2-1:0]    read_cnt_lo,
    output logic [CW/2-1:0]    read_cnt_hi,
    output logic               first_fail_valid,
    output logic [AW-1:0]      first_fail_addr,
    output logic [DW-1:0]      first_fail_exp,
    output logic [DW-1:0]      first_fail_got,
    output logic               traffic_stop,
    output logic               reread_req,
    output logic [AW-1:0]      reread_addr,
    output logic               reread_valid,
    output logic [DW-1:0]      reread_data,
    output logic               pass_o,
    output logic               fail_o
);
    localparam int HW = CW / 2;

    rr_state_e     state;
    logic          cmp_en, mismatch, take_reread;
    logic [DW-1:0] diff;
    logic [CW-1:0] fail_q, tot_q;

    assign cmp_en   = rsp_valid && (state == ST_RUN);
    assign diff     = cmp_en ? (rsp_data ^ exp_data) : '0;
    assign mismatch = |diff;

    rdchk_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .mismatch(mismatch),
        .rsp_addr(rsp_addr), .worm_en(worm_en), .clr_rr(clr[CLR_RR]),
        .state_o(state), .halt_addr(reread_addr), .reread_req(reread_req),
        .traffic_stop(traffic_stop), .take_reread(take_reread)
    );

    rdchk_stat #(.DW(DW), .CW(CW)) u_stat (
        .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .diff(diff),
        .clr_pnf(clr[CLR_PNF]), .clr_tot(clr[CLR_TOT]),
        .pnf_q(pnf_o), .fail_q(fail_q), .tot_q(tot_q)
    );

    rdchk_capture #(.DW(DW), .AW(AW)) u_cap (
        .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .exp_data(exp_data), .take_reread(take_reread),
        .clr_ff(clr[CLR_FF]), .clr_rr(clr[CLR_RR]),
        .ff_valid(first_fail_valid), .ff_addr(first_fail_addr),
        .ff_exp(first_fail_exp), .ff_got(first_fail_got),
        .rr_valid(reread_valid), .rr_data(reread_data)
    );

    assign fail_cnt_lo = fail_q[HW-1:0];
    assign fail_cnt_hi = fail_q[CW-1:HW];
    assign read_cnt_lo = tot_q[HW-1:0];
    assign read_cnt_hi = tot_q[CW-1:HW];
    assign pass_o      = test_done && (&pnf_o);
    assign fail_o      = test_done && !(&pnf_o);

    a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !test_done |-> (!pass_o && !fail_o));
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));
    a_r8_no_count_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (traffic_stop && !clr[CLR_TOT]) |=> $stable(tot_q));
endmodule

// File: tb/test_rdchk.sv
`timescale 1ns/1ps
module test_rdchk;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int CW = 64;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, rsp_valid, worm_en, test_done;
    logic [AW-1:0] rsp_addr;
    logic [DW-1:0] rsp_data, exp_data;
    logic [3:0]    clr;
    logic [DW-1:0] pnf_o, first_fail_exp, first_fail_got, reread_data;
    logic [31:0]   fail_cnt_lo, fail_cnt_hi, read_cnt_lo, read_cnt_hi;
    logic          first_fail_valid, traffic_stop, reread_req, reread_valid, pass_o, fail_o;
    logic [AW-1:0] first_fail_addr, reread_addr;

    rdchk #(.DW(DW), .AW(AW), .CW(CW)) i_rdchk (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .exp_data(exp_data), .worm_en(worm_en),
        .test_done(test_done), .clr(clr), .pnf_o(pnf_o),
        .fail_cnt_lo(fail_cnt_lo), .fail_cnt_hi(fail_cnt_hi),
        .read_cnt_lo(read_cnt_lo), .read_cnt_hi(read_cnt_hi),
        .first_fail_valid(first_fail_valid), .first_fail_addr(first_fail_addr),
        .first_fail_exp(first_fail_exp), .first_fail_got(first_fail_got),
        .traffic_stop(traffic_stop), .reread_req(reread_req), .reread_addr(reread_addr),
        .reread_valid(reread_valid), .reread_data(reread_data),
        .pass_o(pass_o), .fail_o(fail_o)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // reference state built from the requirements
    logic [DW-1:0] m_pnf = '1;
    logic [63:0]   m_fail = 0, m_tot = 0;
    logic          m_ffv = 0, m_rrv = 0;
    logic [AW-1:0] m_ffa = 0, m_ha = 0;
    logic [DW-1:0] m_ffe = 0, m_ffg = 0, m_rrd = 0;
    int            m_st = 0; // 0 run, 1 issue, 2 wait, 3 hold

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
        return v ^ (32'd1 << ($urandom % DW));
    endfunction

    task automatic model_step();
        logic          cmp, mm;
        logic [DW-1:0] df;
        cmp = rsp_valid && (m_st == 0);
        df  = cmp ? (rsp_data ^ exp_data) : '0;
        mm  = (df != 0);
        m_pnf  = (clr[0] ? '1 : m_pnf) & ~df;
        m_fail = (clr[0] ? 64'd0 : m_fail) + {63'd0, mm};
        m_tot  = (clr[1] ? 64'd0 : m_tot) + {63'd0, cmp};
        if (mm && (!m_ffv || clr[2])) begin
            m_ffv = 1; m_ffa = rsp_addr; m_ffe = exp_data; m_ffg = rsp_data;
        end else if (clr[2]) begin
            m_ffv = 0; m_ffa = 0; m_ffe = 0; m_ffg = 0;
        end
        if (m_st == 2 && rsp_valid) begin
            m_rrv = 1; m_rrd = rsp_data;
        end else if (clr[3]) begin
            m_rrv = 0; m_rrd = 0;
        end
        case (m_st)
            0: if (mm && worm_en) begin m_st = 1; m_ha = rsp_addr; end
            1: m_st = 2;
            2: if (rsp_valid) m_st = 3;
            default: if (clr[3]) m_st = 0;
        endcase
    endtask

    task automatic compare_all();
        check("R2 pnf", 64'(pnf_o), 64'(m_pnf));
        check("R3 fail_lo", 64'(fail_cnt_lo), 64'(m_fail[31:0]));
        check("R3 fail_hi", 64'(fail_cnt_hi), 64'(m_fail[63:32]));
        check("R4 read_lo", 64'(read_cnt_lo), 64'(m_tot[31:0]));
        check("R4 read_hi", 64'(read_cnt_hi), 64'(m_tot[63:32]));
        check("R5 ff_valid", 64'(first_fail_valid), 64'(m_ffv));
        check("R5 ff_addr", 64'(first_fail_addr), 64'(m_ffa));
        check("R5 ff_exp", 64'(first_fail_exp), 64'(m_ffe));
        check("R5 ff_got", 64'(first_fail_got), 64'(m_ffg));
        check("R7 stop", 64'(traffic_stop), 64'(m_st != 0));
        check("R7 req", 64'(reread_req), 64'(m_st == 1));
        check("R7 addr", 64'(reread_addr), 64'(m_ha));
        check("R8 rr_valid", 64'(reread_valid), 64'(m_rrv));
        check("R8 rr_data", 64'(reread_data), 64'(m_rrd));
        check("R10 pass", 64'(pass_o), 64'(test_done && (m_pnf == '1)));
        check("R10 fail", 64'(fail_o), 64'(test_done && (m_pnf != '1)));
    endtask

    task automatic cyc(input logic v, input logic [DW-1:0] d, input logic [DW-1:0] e,
                       input logic [AW-1:0] a, input logic [3:0] c, input logic w,
                       input logic dn);
        @(negedge clk);
        rsp_valid = v; rsp_data = d; exp_data = e; rsp_addr = a;
        clr = c; worm_en = w; test_done = dn;
        @(posedge clk);
        model_step();
        #2;
        compare_all();
    endtask

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] e;
        void'($urandom(32'd2024));
        rst_n = 0; rsp_valid = 0; rsp_data = 0; exp_data = 0; rsp_addr = 0;
        clr = 0; worm_en = 0; test_done = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1: reset state
        check("R1 pnf", 64'(pnf_o), 64'(32'hFFFF_FFFF));
        check("R1 counts", 64'(fail_cnt_lo | read_cnt_lo | fail_cnt_hi | read_cnt_hi), 64'd0);
        check("R1 flags", 64'({first_fail_valid, reread_valid, traffic_stop, reread_req, pass_o, fail_o}), 64'd0);

        // R10: clean run reports pass
        cyc(1, 32'hA5A5_0001, 32'hA5A5_0001, 32'h10, 4'h0, 0, 1);
        // R2 R3 R5: two mismatches, first one captured and held
        cyc(1, 32'h0000_00F0, 32'h0000_0000, 32'h20, 4'h0, 0, 0);
        cyc(1, 32'h0F00_0000, 32'h0000_0000, 32'h30, 4'h0, 0, 1);
        // R6: all clears together with a new mismatch
        cyc(1, 32'h0000_0001, 32'h0000_0000, 32'h40, 4'hF, 0, 1);
        // R7 R8 R9: write-once mode sequence
        cyc(0, 0, 0, 0, 4'h7, 0, 0);
        cyc(1, 32'h1111_1111, 32'h1111_1110, 32'h1234, 4'h0, 1, 0);
        cyc(1, 32'h2222_2222, 32'h3333_3333, 32'h50, 4'h0, 1, 0); // ISSUE: ignored
        cyc(0, 0, 0, 0, 4'h0, 1, 0);
        cyc(1, 32'hBEEF_0001, 32'h0, 32'h1234, 4'h0, 1, 0);      // re-read data
        cyc(1, 32'h4444_4444, 32'h5555_5555, 32'h60, 4'h0, 1, 0); // HOLD: ignored
        cyc(0, 0, 0, 0, 4'h8, 1, 1);                              // R9 release
        cyc(1, 32'h7, 32'h7, 32'h70, 4'h0, 0, 1);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic       w;
            logic [3:0] c;
            w = ((i / 300) % 2) == 1;
            e = $urandom;
            c = (($urandom % 30) == 0) ? 4'($urandom % 16) : 4'h0;
            if (w && (($urandom % 8) == 0)) c[3] = 1'b1;
            cyc((($urandom % 4) != 0), ((($urandom % 6) == 0) ? flip(e) : e), e,
                $urandom, c, w, (($urandom % 8) == 0));
        end

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule